// File: doc/BRIEF.md
# Tearing-Synchronized Frame Start Controller

This block decides the cycle in which a command-mode frame transfer begins on each of several virtual channels. Every channel has its own start bit, enable bit, source-select bit and external-line index. Together these pick one of three start sources. The first is a software start. The second is a tearing-effect trigger message that arrives over the serial link, decoded upstream into a strobe and a channel number. The third is a pulse on one of the external tearing-effect pins.

Each external pin has a pulse-width classifier. A pin can be set to start transfers on a vertical event (a long pulse). It can also be set to start after a programmed number of horizontal events (shorter pulses) counted since the last vertical event. One pin can start several channels in the same cycle. When the downstream packetiser reports that a channel's transfer is complete, the channel's start and enable bits clear themselves. An interrupt pulse tells software that a trigger message was received, so that software-started transfers can be timed from it.

Top module: `te_frame_starter`

## Requirements
- R1: After reset, `xfer_start`, `trig_irq`, `start_bit` and `en_bit` are all zero.
- R2: A channel whose start bit is set while its enable bit is clear issues exactly one `xfer_start` pulse. Its start bit reads 1 until that transfer completes.
- R3: `xfer_done` on a channel with a transfer in flight clears both the start and the enable bit of that channel on the next cycle. A clear and a set in the same cycle resolve to clear.
- R4: With enable set and line-select clear, a trigger message whose channel field equals the channel number starts that channel. A message with another channel number does not.
- R5: `trig_irq` is high for exactly the cycle after each cycle with `msg_valid` high, whatever the channels' modes.
- R6: With enable and line-select set, the selected pin's count mode 0 starts the channel when a high pulse of at least `vs_width` clock cycles ends. A shorter pulse does not start it.
- R7: In count mode 1, pulses of at least `hs_width` cycles but shorter than `vs_width` count as horizontal events. The count resets on every vertical pulse. The channel starts on the horizontal event that brings the count to `hs_count`. Pulses shorter than `hs_width` are not counted, and `hs_count` = 0 never starts a transfer.
- R8: One pin event starts every enabled line-mode channel whose line index (bit field `i` of `cfg_line_idx`) selects that pin, in the same cycle. Channels that select the other pin do not start.
- R9: A trigger that arrives while a channel's transfer is in flight produces no second pulse and leaves the enable bit set.
- R10: A trigger from the source that was not selected is ignored. A message does not start a line-mode channel, and a pin event does not start a message-mode channel.
- R11: Each `xfer_start` pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_start_set | input | NCH | Per-channel pulse that sets the start bit |
| cfg_en_set | input | NCH | Per-channel pulse that sets the enable bit |
| cfg_line_mode | input | NCH | Per-channel source select: 0 message, 1 external pin |
| cfg_line_idx | input | NCH*LW | Per-channel pin index, field i at [i*LW +: LW] |
| cfg_vs_width | input | NL*CW | Per-pin minimum vertical pulse width in cycles |
| cfg_hs_width | input | NL*CW | Per-pin minimum horizontal pulse width in cycles |
| cfg_hs_count | input | NL*CW | Per-pin horizontal events needed to start |
| cfg_count_h | input | NL | Per-pin mode: 0 vertical start, 1 horizontal count |
| msg_valid | input | 1 | Decoded trigger-message strobe |
| msg_ch | input | CHW | Channel number carried by the trigger message |
| te_pin | input | NL | External tearing-effect pins (asynchronous) |
| xfer_done | input | NCH | Per-channel transfer-complete strobe |
| xfer_start | output | NCH | Per-channel one-cycle start pulse |
| trig_irq | output | 1 | One-cycle pulse after a trigger message |
| start_bit | output | NCH | Start bits, cleared by hardware |
| en_bit | output | NCH | Enable bits, cleared by hardware |

## Verification
The bench targets retriggering while a channel is busy. A design that ignored the busy state would emit a second start, and the scoreboard would flag it as unexpected. The bench feeds pulses one cycle below each width threshold and one junk pulse between horizontal events. A classifier using the wrong comparison would start early or miscount, so the expected item would arrive at the wrong point. It also sends a message numbered for another channel, triggers from the unselected source, and uses a zero horizontal count. A design with loose decoding would start a channel that should stay idle, which shows up as an unexpected pulse or a cleared enable bit. The fan-out case expects two channels to start together while a third stays idle, which catches a broken pin-index mux.

// File: rtl/te_start_pkg.sv
// Shared types for the frame start controller.
// Assumes: start/enable/line-select bits follow the three-source decode below.
package te_start_pkg;

    typedef enum logic [1:0] {
        SRC_IDLE   = 2'd0,
        SRC_MANUAL = 2'd1,
        SRC_MSG    = 2'd2,
        SRC_LINE   = 2'd3
    } start_src_e;

    // Map the three per-channel control bits to the active start source.
    function automatic start_src_e decode_src(input logic start_b,
                                              input logic en_b,
                                              input logic line_b);
        if (en_b)         return line_b ? SRC_LINE : SRC_MSG;
        else if (start_b) return SRC_MANUAL;
        else              return SRC_IDLE;
    endfunction

endpackage

// File: rtl/te_line_detect.sv
// Classifies pulses on one external tearing-effect pin by width and emits a
// one-cycle event. It either fires on a vertical pulse or counts horizontal pulses.
// Assumes: pin is asynchronous; width is measured after a two-flop synchronizer.
module te_line_detect #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin,
    input  logic [CW-1:0] vs_w,
    input  logic [CW-1:0] hs_w,
    input  logic [CW-1:0] hs_num,
    input  logic          count_h,
    output logic          evt
);
    localparam logic [CW-1:0] ONE  = CW'(1);
    localparam logic [CW-1:0] SATV = {CW{1'b1}};

    logic          s1, s2, s3;
    logic [CW-1:0] wid;
    logic [CW-1:0] hcnt;
    logic [CW-1:0] hnext;
    logic          fall, is_vs, is_hs;

    // Synchronize the pin and keep the previous synced value for edge detect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
        end else begin
            s1 <= pin; s2 <= s1; s3 <= s2;
        end
    end

    assign fall  = s3 && !s2;
    assign is_vs = fall && (wid >= vs_w);
    assign is_hs = fall && !is_vs && (wid >= hs_w);
    assign hnext = hcnt + ONE;

    // Measure the high time of the synced pin, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)       wid <= '0;
        else if (!s2)     wid <= '0;
        else if (wid != SATV) wid <= wid + ONE;
    end

    // Count horizontal pulses since the last vertical pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)                        hcnt <= '0;
        else if (is_vs)                    hcnt <= '0;
        else if (is_hs && hcnt != SATV)    hcnt <= hnext;
    end

    // Produce the start event for the selected counting mode.
    always_ff @(posedge clk) begin
        if (!rst_n) evt <= 1'b0;
        else if (count_h)
            evt <= is_hs && (hs_num != '0) && (hcnt != SATV) && (hnext == hs_num);
        else
            evt <= is_vs;
    end

    // R6
    vs_evt_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !count_h) |-> $past(wid >= vs_w));

    // R7
    evt_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> $past(s3 && !s2));

endmodule

// File: rtl/te_chan_ctrl.sv
// Per-channel start control. It holds the start and enable bits, picks the
// source and issues one start pulse per transfer. Done clears the bits.
// Assumes: msg_hit and line_evt are single-cycle strobes already routed here.
module te_chan_ctrl
    import te_start_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_set,
    input  logic en_set,
    input  logic line_mode,
    input  logic msg_hit,
    input  logic line_evt,
    input  logic done,
    output logic xfer_start,
    output logic start_bit,
    output logic en_bit
);
    start_src_e src;
    logic       busy;
    logic       fire;

    assign src  = decode_src(start_bit, en_bit, line_mode);
    assign fire = !busy && ((src == SRC_MANUAL) ||
                            (src == SRC_MSG  && msg_hit) ||
                            (src == SRC_LINE && line_evt));

    // Issue the start pulse and track the in-flight transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_start <= 1'b0;
            busy       <= 1'b0;
        end else begin
            xfer_start <= fire;
            if (fire)      busy <= 1'b1;
            else if (done) busy <= 1'b0;
        end
    end

    // Software sets the bits; completion of a transfer clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_bit <= 1'b0;
            en_bit    <= 1'b0;
        end else if (busy && done) begin
            start_bit <= 1'b0;
            en_bit    <= 1'b0;
        end else begin
            if (start_set) start_bit <= 1'b1;
            if (en_set)    en_bit    <= 1'b1;
        end
    end

    // R11
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);

    // R3
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && done) |=> (!start_bit && !en_bit));

    // R2
    start_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> $past(start_bit || en_bit));

endmodule

// File: rtl/te_frame_starter.sv
// Top level: one pulse classifier per external pin and one controller per
// virtual channel. Routes trigger messages by channel number and pin events
// by each channel's line index.
// Assumes: msg_ch is valid whenever msg_valid is high.
module te_frame_starter #(
    parameter int NCH = 4,
    parameter int NL  = 2,
    parameter int CW  = 8,
    parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    parameter int LW  = (NL > 1) ? $clog2(NL) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    cfg_start_set,
    input  logic [NCH-1:0]    cfg_en_set,
    input  logic [NCH-1:0]    cfg_line_mode,
    input  logic [NCH*LW-1:0] cfg_line_idx,
    input  logic [NL*CW-1:0]  cfg_vs_width,
    input  logic [NL*CW-1:0]  cfg_hs_width,
    input  logic [NL*CW-1:0]  cfg_hs_count,
    input  logic [NL-1:0]     cfg_count_h,
    input  logic              msg_valid,
    input  logic [CHW-1:0]    msg_ch,
    input  logic [NL-1:0]     te_pin,
    input  logic [NCH-1:0]    xfer_done,
    output logic [NCH-1:0]    xfer_start,
    output logic              trig_irq,
    output logic [NCH-1:0]    start_bit,
    output logic [NCH-1:0]    en_bit
);
    logic [NL-1:0] line_evt;

    // Raise the interrupt one cycle after any received trigger message.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_irq <= 1'b0;
        else        trig_irq <= msg_valid;
    end

    for (genvar l = 0; l < NL; l++) begin : g_line
        te_line_detect #(.CW(CW)) u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin     (te_pin[l]),
            .vs_w    (cfg_vs_width[l*CW +: CW]),
            .hs_w    (cfg_hs_width[l*CW +: CW]),
            .hs_num  (cfg_hs_count[l*CW +: CW]),
            .count_h (cfg_count_h[l]),
            .evt     (line_evt[l])
        );
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [LW-1:0] idx;
        logic          sel_evt;
        logic          hit;

        assign idx     = cfg_line_idx[i*LW +: LW];
        assign sel_evt = (int'(idx) < NL) ? line_evt[idx] : 1'b0;
        assign hit     = msg_valid && (msg_ch == CHW'(i));

        te_chan_ctrl u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .start_set  (cfg_start_set[i]),
            .en_set     (cfg_en_set[i]),
            .line_mode  (cfg_line_mode[i]),
            .msg_hit    (hit),
            .line_evt   (sel_evt),
            .done       (xfer_done[i]),
            .xfer_start (xfer_start[i]),
            .start_bit  (start_bit[i]),
            .en_bit     (en_bit[i])
        );
    end

    // R5
    irq_follows_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_irq |-> $past(msg_valid));

endmodule

// File: tb/sim_te_frame_starter.sv
// Scoreboard bench: tasks queue the expected starting channels; a monitor
// pops and compares on every start pulse.
module sim_te_frame_starter;
    localparam int NCH = 4, NL = 2, CW = 8, CHW = 2, LW = 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    cfg_start_set = '0, cfg_en_set = '0, cfg_line_mode = '0;
    logic [NCH*LW-1:0] cfg_line_idx = '0;
    logic [NL*CW-1:0]  cfg_vs_width = '0, cfg_hs_width = '0, cfg_hs_count = '0;
    logic [NL-1:0]     cfg_count_h = '0;
    logic              msg_valid = 1'b0;
    logic [CHW-1:0]    msg_ch = '0;
    logic [NL-1:0]     te_pin = '0;
    logic [NCH-1:0]    xfer_done = '0;
    logic [NCH-1:0]    xfer_start;
    logic              trig_irq;
    logic [NCH-1:0]    start_bit, en_bit;

    int    total = 0, bad = 0;
    int    exp_q[$];
    string cur_req = "R1";

    always #10 clk = ~clk;

    te_frame_starter #(.NCH(NCH), .NL(NL), .CW(CW)) u0 (.*);

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: every start pulse must match the head of the expected queue.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                if (xfer_start[i]) begin
                    if (exp_q.size() == 0) check(1'b0, cur_req, i, -1);
                    else begin
                        int e;
                        e = exp_q.pop_front();
                        check(e == i, cur_req, i, e);
                    end
                end
            end
        end
    end

    task automatic set_start(input int ch);
        cfg_start_set[ch] = 1'b1; tick(1); cfg_start_set[ch] = 1'b0; tick(3);
    endtask

    task automatic set_en(input int ch, input bit lm, input int idx);
        cfg_line_mode[ch] = lm;
        cfg_line_idx[ch*LW +: LW] = LW'(idx);
        cfg_en_set[ch] = 1'b1; tick(1); cfg_en_set[ch] = 1'b0; tick(2);
    endtask

    task automatic finish_xfer(input int ch);
        xfer_done[ch] = 1'b1; tick(1); xfer_done[ch] = 1'b0; tick(2);
    endtask

    task automatic send_msg(input int ch);
        msg_ch = CHW'(ch); msg_valid = 1'b1; tick(1); msg_valid = 1'b0;
        check(trig_irq == 1'b1, "R5", int'(trig_irq), 1);
        tick(1);
        check(trig_irq == 1'b0, "R5", int'(trig_irq), 0);
        tick(4);
    endtask

    task automatic pulse_pin(input int ln, input int w);
        te_pin[ln] = 1'b1; tick(w); te_pin[ln] = 1'b0; tick(8);
    endtask

    task automatic queue_empty(input string req);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cfg_vs_width = {8'd10, 8'd8};
        cfg_hs_width = {8'd2,  8'd2};
        cfg_hs_count = {8'd3,  8'd3};
        tick(4); rst_n = 1'b1; tick(1);

        // R1 reset state
        check(xfer_start == '0 && trig_irq == 1'b0, "R1", int'(xfer_start), 0);
        check(start_bit == '0 && en_bit == '0, "R1", int'({start_bit, en_bit}), 0);

        // R2 manual start, R3 clear on done
        cur_req = "R2";
        exp_q.push_back(0);
        set_start(0);
        check(start_bit[0] == 1'b1, "R2", int'(start_bit[0]), 1);
        queue_empty("R2");
        finish_xfer(0);
        check(start_bit[0] == 1'b0, "R3", int'(start_bit[0]), 0);

        // R4 message routing, R9 busy retrigger
        cur_req = "R4";
        set_en(1, 1'b0, 0);
        send_msg(2);
        check(en_bit[1] == 1'b1, "R4", int'(en_bit[1]), 1);
        exp_q.push_back(1);
        send_msg(1);
        queue_empty("R4");
        cur_req = "R9";
        send_msg(1);
        check(en_bit[1] == 1'b1, "R9", int'(en_bit[1]), 1);
        finish_xfer(1);
        check(en_bit[1] == 1'b0, "R3", int'(en_bit[1]), 0);

        // R6 vertical width threshold, R8 fan-out
        cur_req = "R6";
        set_en(2, 1'b1, 0);
        set_en(3, 1'b1, 0);
        set_en(0, 1'b1, 1);
        pulse_pin(0, 7);
        check(en_bit[2] && en_bit[3], "R6", int'(en_bit), 13);
        cur_req = "R8";
        exp_q.push_back(2); exp_q.push_back(3);
        pulse_pin(0, 8);
        queue_empty("R8");
        check(en_bit[0] == 1'b1, "R8", int'(en_bit[0]), 1);
        finish_xfer(2); finish_xfer(3);
        cur_req = "R6";
        exp_q.push_back(0);
        pulse_pin(1, 10);
        queue_empty("R6");
        finish_xfer(0);

        // R7 horizontal counting
        cur_req = "R7";
        cfg_count_h[0] = 1'b1;
        set_en(2, 1'b1, 0);
        pulse_pin(0, 9);
        pulse_pin(0, 2);
        pulse_pin(0, 1);
        pulse_pin(0, 7);
        check(en_bit[2] == 1'b1, "R7", int'(en_bit[2]), 1);
        exp_q.push_back(2);
        pulse_pin(0, 2);
        queue_empty("R7");
        finish_xfer(2);
        cfg_hs_count[7:0] = 8'd0;
        set_en(2, 1'b1, 0);
        pulse_pin(0, 9);
        pulse_pin(0, 2);
        pulse_pin(0, 2);
        check(en_bit[2] == 1'b1, "R7", int'(en_bit[2]), 1);

        // R10 unselected source ignored
        cur_req = "R10";
        cfg_count_h[0] = 1'b0;
        set_en(3, 1'b1, 0);
        set_en(1, 1'b0, 0);
        send_msg(3);
        check(en_bit[3] == 1'b1, "R10", int'(en_bit[3]), 1);
        exp_q.push_back(2); exp_q.push_back(3);
        pulse_pin(0, 8);
        check(en_bit[1] == 1'b1, "R10", int'(en_bit[1]), 1);
        queue_empty("R10");

        tick(5);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule